// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 96 interrupt request lines and drives one interrupt line to a processor. Software reaches it through a plain 32-bit register port that has an address, write data, a write strobe, a read strobe and registered read data. The request lines are grouped in banks of 32. Request n is bit n mod 32 of bank n div 32. Each bank has a pending register, an enable register and a mask register. A single vector register gives the number of the lowest-numbered request that is ready to be served.

Request 0 is a dedicated external line. Its trigger type is set in a control register and it has sticky pending behaviour. Requests 1 to 95 are level lines that latch while they are active. A protection register can make the controller drop every write that does not carry the privileged qualifier. A parameter chooses between two placements of the enable and mask banks.

Top module: `vec_intc`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: The vector register at offset 0x00 reads the index of the lowest-numbered eligible request, multiplied by four, with bits [1:0] zero. A request is eligible when it is pending, enabled and unmasked. The register reads zero when no request is eligible.
- R3: A request whose enable bit is 0 raises neither `irq_o` nor the vector. Its pending bit can still be read.
- R4: A mask bit of 1 blocks its request from `irq_o` and from the vector in the same way.
- R5: Writing 1 to a bit of a pending register clears that bit, and writing 0 leaves it unchanged. For requests 1 to 95 the clear has no effect while the input is still high.
- R6: For requests 1 to 95, the pending bit is set one clock after the input is seen high. The bit stays set after the input drops, until software clears it.
- R7: Bits [1:0] of the external control register at 0x0c select the trigger of request 0. The codes are 0 = low level, 1 = high level, 2 = falling edge and 3 = rising edge. Pending bit 0 then stays set until a write-1 clear. The clear loses to a trigger event in the same cycle.
- R8: When request 0 is the one selected, the vector reads zero. Bit 0 of the pending register at 0x10 then reads 1, which tells this case apart from the idle case.
- R9: Bit 0 of the protection register at 0x08 turns protection on. While it is set, writes with `bus_priv_i` low change no register, including the protection register itself. Writes with `bus_priv_i` high still take effect.
- R10: `irq_o` is high exactly when at least one request is eligible.
- R11: Pending bank b sits at 0x10+4b. Enable bank b sits at EN+4b and mask bank b at MK+4b. (EN, MK) is (0x40, 0x50) when `ALT_LAYOUT` is 0 and (0x20, 0x30) when it is 1.
- R12: A read returns data on `bus_rdata_o` one clock after `bus_rd_i` is sampled high. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe |
| bus_priv_i | input | 1 | Privileged access qualifier |
| bus_rdata_o | output | 32 | Registered read data |
| src_i | input | NUM_SRC | Request lines; bit 0 is the external line |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
The priority encoder is driven by pairs of active requests. The pairs sit at the same index, in the same bank, across a bank boundary (31 against 32), at the top of the range and against request 1. This separates a correct lowest-first choice from highest-first or per-bank selection. Request 0 is stepped through all four trigger codes with input sequences that fire only under the intended code, and one case sets request 0 together with a level request to show the zero vector is still distinguished by pending bit 0. Enable, mask, protection and clear-while-high tests each use a request that would otherwise be eligible, so a gating fault shows on `irq_o` or the vector.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;

    localparam int ADDR_W = 8;
    localparam int REG_W  = 32;

    localparam logic [ADDR_W-1:0] OFF_VECTOR = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_PROT   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_EXTCTL = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_PEND   = 8'h10;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_RISE = 2'd3
    } trig_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  wdata;
        logic              wr;
        logic              rd;
        logic              priv;
    } bus_req_t;

    function automatic logic [ADDR_W-1:0] en_base(input bit alt);
        return alt ? 8'h20 : 8'h40;
    endfunction

    function automatic logic [ADDR_W-1:0] mask_base(input bit alt);
        return alt ? 8'h30 : 8'h50;
    endfunction

    function automatic logic ext_fire(input trig_e mode, input logic cur, input logic prev);
        logic hit;
        unique case (mode)
            TRIG_LOW:  hit = ~cur;
            TRIG_HIGH: hit = cur;
            TRIG_FALL: hit = prev & ~cur;
            TRIG_RISE: hit = ~prev & cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/vec_intc_pend.sv
module vec_intc_pend
    import vec_intc_pkg::*;
#(
    parameter int NUM_SRC = 96
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  trig_e              trig_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);

    logic [NUM_SRC-1:0] pend_q;
    logic               ext_prev_q;
    logic               ext_set;

    assign ext_set = ext_fire(trig_i, src_i[0], ext_prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q[0]  <= 1'b0;
            ext_prev_q <= 1'b0;
        end else begin
            pend_q[0]  <= ext_set | (pend_q[0] & ~clr_i[0]);
            ext_prev_q <= src_i[0];
        end
    end

    for (genvar i = 1; i < NUM_SRC; i++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst) pend_q[i] <= 1'b0;
            else     pend_q[i] <= src_i[i] | (pend_q[i] & ~clr_i[i]);
        end
    end

    assign pend_o = pend_q;

    AST_LVL_SET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q[NUM_SRC-1:1] & $past(src_i[NUM_SRC-1:1])) == $past(src_i[NUM_SRC-1:1]))); // R6

    AST_NO_SILENT_DROP: assert property (@(posedge clk) disable iff (rst)
        (clr_i == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R5

endmodule

// File: rtl/vec_intc_sel.sv
module vec_intc_sel #(
    parameter int NUM_SRC = 96,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] elig;
    logic [IDX_W-1:0]   idx;

    assign elig = pend_i & en_i & ~mask_i;

    always_comb begin
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) idx = IDX_W'(i);
        end
    end

    assign idx_o = idx;
    assign irq_o = |elig;

    AST_VEC_IS_ELIG: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> elig[idx_o]); // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> (idx_o == '0)); // R2

    AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((pend_i & en_i & ~mask_i) == '0) |-> !irq_o); // R10

endmodule

// File: rtl/vec_intc_regs.sv
module vec_intc_regs
    import vec_intc_pkg::*;
#(
    parameter int NUM_SRC    = 96,
    parameter bit ALT_LAYOUT = 1'b0,
    localparam int NBANK     = (NUM_SRC + REG_W - 1) / REG_W,
    localparam int IDX_W     = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] mask_o,
    output trig_e              trig_o,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [REG_W-1:0]   rdata_o
);

    localparam logic [ADDR_W-1:0] EN_OFF = en_base(ALT_LAYOUT);
    localparam logic [ADDR_W-1:0] MK_OFF = mask_base(ALT_LAYOUT);
    localparam int FLAT_W = NBANK * REG_W;

    logic [NBANK-1:0][REG_W-1:0] en_q, mask_q;
    logic                        prot_q;
    trig_e                       trig_q;
    logic                        wr_ok;
    logic [FLAT_W-1:0]           pend_flat, clr_flat, en_flat, mask_flat;
    logic [REG_W-1:0]            rd_val;

    assign wr_ok     = req_i.wr & (~prot_q | req_i.priv);
    assign pend_flat = FLAT_W'(pend_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q <= 1'b0;
            trig_q <= TRIG_LOW;
        end else if (wr_ok) begin
            if (req_i.addr == OFF_PROT)   prot_q <= req_i.wdata[0];
            if (req_i.addr == OFF_EXTCTL) trig_q <= trig_e'(req_i.wdata[1:0]);
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] A_PEND = OFF_PEND + ADDR_W'(4 * b);
        localparam logic [ADDR_W-1:0] A_EN   = EN_OFF   + ADDR_W'(4 * b);
        localparam logic [ADDR_W-1:0] A_MK   = MK_OFF   + ADDR_W'(4 * b);

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[b]   <= '0;
                mask_q[b] <= '0;
            end else if (wr_ok) begin
                if (req_i.addr == A_EN) en_q[b]   <= req_i.wdata;
                if (req_i.addr == A_MK) mask_q[b] <= req_i.wdata;
            end
        end

        assign clr_flat[b*REG_W +: REG_W] =
            (wr_ok && req_i.addr == A_PEND) ? req_i.wdata : '0;
        assign en_flat[b*REG_W +: REG_W]   = en_q[b];
        assign mask_flat[b*REG_W +: REG_W] = mask_q[b];
    end

    always_comb begin
        rd_val = '0;
        if (req_i.addr == OFF_VECTOR) rd_val = REG_W'(idx_i) << 2;
        if (req_i.addr == OFF_PROT)   rd_val = {{(REG_W-1){1'b0}}, prot_q};
        if (req_i.addr == OFF_EXTCTL) rd_val = {{(REG_W-2){1'b0}}, trig_q};
        for (int b = 0; b < NBANK; b++) begin
            if (req_i.addr == OFF_PEND + ADDR_W'(4 * b)) rd_val = pend_flat[b*REG_W +: REG_W];
            if (req_i.addr == EN_OFF   + ADDR_W'(4 * b)) rd_val = en_q[b];
            if (req_i.addr == MK_OFF   + ADDR_W'(4 * b)) rd_val = mask_q[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           rdata_o <= '0;
        else if (req_i.rd) rdata_o <= rd_val;
    end

    assign en_o   = en_flat[NUM_SRC-1:0];
    assign mask_o = mask_flat[NUM_SRC-1:0];
    assign clr_o  = clr_flat[NUM_SRC-1:0];
    assign trig_o = trig_q;

    AST_PROT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (prot_q && req_i.wr && !req_i.priv) |=>
        ($stable(en_q) && $stable(mask_q) && $stable(prot_q) && $stable(trig_q))); // R9

    AST_PROT_NO_CLR: assert property (@(posedge clk) disable iff (rst)
        (prot_q && !req_i.priv) |-> (clr_o == '0)); // R9

endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vec_intc_pkg::*;
#(
    parameter int NUM_SRC    = 96,
    parameter bit ALT_LAYOUT = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic               bus_priv_i,
    output logic [31:0]        bus_rdata_o,
    input  logic [NUM_SRC-1:0] src_i,
    output logic               irq_o
);

    localparam int IDX_W = $clog2(NUM_SRC);

    bus_req_t           req;
    logic [NUM_SRC-1:0] pend, en, mask, clr;
    logic [IDX_W-1:0]   idx;
    trig_e              trig;

    assign req = '{addr: bus_addr_i, wdata: bus_wdata_i, wr: bus_wr_i,
                   rd: bus_rd_i, priv: bus_priv_i};

    vec_intc_regs #(.NUM_SRC(NUM_SRC), .ALT_LAYOUT(ALT_LAYOUT)) u_regs (
        .clk(clk), .rst(rst), .req_i(req), .pend_i(pend), .idx_i(idx),
        .en_o(en), .mask_o(mask), .trig_o(trig), .clr_o(clr), .rdata_o(bus_rdata_o)
    );

    vec_intc_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst(rst), .src_i(src_i), .trig_i(trig), .clr_i(clr), .pend_o(pend)
    );

    vec_intc_sel #(.NUM_SRC(NUM_SRC)) u_sel (
        .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .mask_i(mask),
        .idx_o(idx), .irq_o(irq_o)
    );

    AST_DISABLED_SRC0: assert property (@(posedge clk) disable iff (rst)
        (!en[0] && (pend[NUM_SRC-1:1] & en[NUM_SRC-1:1] & ~mask[NUM_SRC-1:1]) == '0) |-> !irq_o); // R3

endmodule

// File: tb/vec_intc_tb.sv
module vec_intc_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0, rd = 1'b0, priv = 1'b0;
    logic [31:0] rdata;
    logic [95:0] src = 96'h1;
    logic        irq;
    int          n_run = 0, n_fail = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    vec_intc u_dut (
        .clk(clk), .rst(rst), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_priv_i(priv), .bus_rdata_o(rdata),
        .src_i(src), .irq_o(irq)
    );

    localparam int NPAIR = 6;
    localparam int PA[NPAIR]   = '{5, 40, 95, 31, 63, 1};
    localparam int PB[NPAIR]   = '{5, 70, 64, 32, 94, 90};
    localparam int PEXP[NPAIR] = '{32'h14, 32'hA0, 32'h100, 32'h7C, 32'hFC, 32'h04};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; priv = p;
        @(negedge clk);
        wr = 1'b0; priv = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic clear_all();
        for (int b = 0; b < 3; b++) wr_reg(8'h10 + 8'(4*b), 32'hFFFF_FFFF, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();

        // R1 reset state, R12 unmapped offset
        chk("R1 irq", {31'b0, irq}, 32'h0);
        begin
            logic [7:0] offs [12] = '{8'h00, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                                      8'h40, 8'h44, 8'h48, 8'h50, 8'h54, 8'h58};
            for (int k = 0; k < 12; k++) begin
                rd_reg(offs[k], d);
                chk("R1 reg", d, 32'h0);
            end
        end

        // R11 layout: enable/mask banks at 0x40/0x50
        wr_reg(8'h48, 32'hA5A5_0F0F, 1'b0);
        wr_reg(8'h54, 32'h1234_5678, 1'b0);
        rd_reg(8'h48, d); chk("R11 enable bank2", d, 32'hA5A5_0F0F);
        rd_reg(8'h54, d); chk("R11 mask bank1", d, 32'h1234_5678);
        rd_reg(8'h7C, d); chk("R12 unmapped", d, 32'h0);
        wr_reg(8'h54, 32'h0, 1'b0);

        // R3 enable gating: source 10 pending while disabled
        wr_reg(8'h40, 32'h0, 1'b0);
        src[10] = 1'b1; tick(); tick();
        chk("R3 irq disabled", {31'b0, irq}, 32'h0);
        rd_reg(8'h00, d); chk("R3 vector disabled", d, 32'h0);
        rd_reg(8'h10, d); chk("R3 pending visible", d, 32'h400);

        // enable everything (bank0 without source 0)
        wr_reg(8'h40, 32'hFFFF_FFFE, 1'b0);
        wr_reg(8'h44, 32'hFFFF_FFFF, 1'b0);
        wr_reg(8'h48, 32'hFFFF_FFFF, 1'b0);
        chk("R10 irq enabled", {31'b0, irq}, 32'h1);
        rd_reg(8'h00, d); chk("R2 vector src10", d, 32'h28);

        // R4 mask
        wr_reg(8'h50, 32'h400, 1'b0);
        chk("R4 irq masked", {31'b0, irq}, 32'h0);
        rd_reg(8'h00, d); chk("R4 vector masked", d, 32'h0);
        wr_reg(8'h50, 32'h0, 1'b0);
        chk("R4 irq unmasked", {31'b0, irq}, 32'h1);

        // R5 / R6 clear semantics on a level source
        wr_reg(8'h10, 32'h400, 1'b0);
        chk("R5 clear ignored while high", {31'b0, irq}, 32'h1);
        src[10] = 1'b0; tick(); tick();
        chk("R6 latched after drop", {31'b0, irq}, 32'h1);
        wr_reg(8'h10, 32'h0, 1'b0);
        rd_reg(8'h10, d); chk("R5 write0 keeps", d, 32'h400);
        wr_reg(8'h10, 32'h400, 1'b0);
        rd_reg(8'h10, d); chk("R5 write1 clears", d, 32'h0);
        chk("R10 irq idle", {31'b0, irq}, 32'h0);

        // R2 priority table
        for (int k = 0; k < NPAIR; k++) begin
            src[PA[k]] = 1'b1; src[PB[k]] = 1'b1;
            tick(); tick();
            rd_reg(8'h00, d); chk("R2 vector pair", d, PEXP[k]);
            chk("R10 irq pair", {31'b0, irq}, 32'h1);
            src[PA[k]] = 1'b0; src[PB[k]] = 1'b0;
            tick();
            clear_all();
            chk("R5 cleared pair", {31'b0, irq}, 32'h0);
        end

        // R7 / R8 external source, enable bit 0
        wr_reg(8'h40, 32'hFFFF_FFFF, 1'b0);
        wr_reg(8'h0C, 32'h3, 1'b0);                    // rising
        rd_reg(8'h0C, d); chk("R7 ctl readback", d, 32'h3);
        src[0] = 1'b0; tick(); tick();
        chk("R7 rise: no fire on fall", {31'b0, irq}, 32'h0);
        src[0] = 1'b1; tick(); tick();
        chk("R7 rise fires", {31'b0, irq}, 32'h1);
        rd_reg(8'h00, d); chk("R8 vector src0", d, 32'h0);
        rd_reg(8'h10, d); chk("R8 pending bit0", d, 32'h1);
        wr_reg(8'h10, 32'h1, 1'b0);
        chk("R7 rise cleared", {31'b0, irq}, 32'h0);

        wr_reg(8'h0C, 32'h2, 1'b0);                    // falling
        tick();
        chk("R7 fall quiet while high", {31'b0, irq}, 32'h0);
        src[0] = 1'b0; tick(); tick();
        chk("R7 fall fires", {31'b0, irq}, 32'h1);
        wr_reg(8'h10, 32'h1, 1'b0);
        chk("R7 fall cleared", {31'b0, irq}, 32'h0);

        wr_reg(8'h0C, 32'h1, 1'b0);                    // high level
        tick();
        chk("R7 high quiet while low", {31'b0, irq}, 32'h0);
        src[0] = 1'b1; tick(); tick();
        src[0] = 1'b0; tick(); tick();
        chk("R7 high sticky", {31'b0, irq}, 32'h1);
        src[7] = 1'b1; tick(); tick();
        rd_reg(8'h00, d); chk("R8 src0 beats src7", d, 32'h0);
        src[7] = 1'b0; tick();
        clear_all();

        wr_reg(8'h0C, 32'h0, 1'b0);                    // low level
        tick();
        chk("R7 low fires", {31'b0, irq}, 32'h1);
        wr_reg(8'h10, 32'h1, 1'b0);
        chk("R7 low clear loses to event", {31'b0, irq}, 32'h1);
        src[0] = 1'b1; tick();
        wr_reg(8'h10, 32'h1, 1'b0);
        chk("R7 low cleared", {31'b0, irq}, 32'h0);

        // R9 protection
        wr_reg(8'h08, 32'h1, 1'b0);
        rd_reg(8'h08, d); chk("R9 prot set", d, 32'h1);
        wr_reg(8'h44, 32'h0, 1'b0);
        rd_reg(8'h44, d); chk("R9 unpriv write dropped", d, 32'hFFFF_FFFF);
        src[40] = 1'b1; tick(); src[40] = 1'b0; tick(); tick();
        wr_reg(8'h14, 32'h100, 1'b0);
        chk("R9 unpriv clear dropped", {31'b0, irq}, 32'h1);
        wr_reg(8'h08, 32'h0, 1'b0);
        rd_reg(8'h08, d); chk("R9 prot self-locked", d, 32'h1);
        wr_reg(8'h14, 32'h100, 1'b1);
        chk("R9 priv clear works", {31'b0, irq}, 32'h0);
        wr_reg(8'h44, 32'h0, 1'b1);
        rd_reg(8'h44, d); chk("R9 priv write works", d, 32'h0);
        wr_reg(8'h08, 32'h0, 1'b1);
        rd_reg(8'h08, d); chk("R9 prot cleared", d, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule